// File: doc/BRIEF.md
# Instruction Field Sequencer

This block takes a stream of instruction bytes, one per valid/ready beat, and cuts each variable-length instruction into its fields. It works out the leading prefix bytes on its own. It places each prefix in one of four groups and records a per-group bitmask. The first byte that is not a prefix starts the opcode.

For every opcode byte the block presents that byte and its position on a combinational lookup port. The lookup answers in the same cycle with four things: whether another opcode byte follows, whether a ModR/M byte is present, the displacement size code and the immediate size code. The sequencer then collects the ModR/M byte, an SIB byte when the ModR/M byte calls for one, the displacement and the immediate. It presents one record per instruction holding every field and the total byte count.

The record waits on its own valid/ready port, and no input byte is accepted while it waits. Decode tables and any mode-dependent resizing belong to whatever drives the lookup port.

Top module: `ifld_seq`

## Requirements
- R1: Fields are taken in a fixed order: prefixes, opcode bytes, ModR/M, SIB, displacement, immediate. `rec_valid_o` rises in the cycle after the handshake of the final byte of an instruction, and stays low until then.
- R2: The prefix codes and their mask bits are as follows. Group 1 uses `rec_grp1_o`: F0h sets bit 0, F2h sets bit 1 and F3h sets bit 2. Group 2 uses `rec_grp2_o`: 26h sets bit 0, 2Eh bit 1, 36h bit 2, 3Eh bit 3, 64h bit 4 and 65h bit 5. 66h sets `rec_grp3_o` and 67h sets `rec_grp4_o`. Prefixes may come in any order, and one prefix from each group raises no error.
- R3: A prefix from a group already seen, or a prefix after four others, sets `rec_err_o`. That byte still counts as a prefix: its mask bit is ORed in and it adds to the length.
- R4: While an opcode byte is offered, `lk_byte_o` equals `in_byte_i` and `lk_idx_o` holds the number of opcode bytes already taken. Opcode bytes are taken until the lookup reports no more bytes, or until three bytes have been taken; at three, a "more" answer is ignored. The bytes appear in `rec_opc_o`, first byte in bits 7:0, and their count appears in `rec_opc_cnt_o`.
- R5: When the lookup reports a ModR/M byte for the last opcode byte, the next byte is captured in `rec_modrm_o` and `rec_has_modrm_o` is set. Its mod field is bits 7:6 and its r/m field is bits 2:0.
- R6: An SIB byte follows the ModR/M byte exactly when mod is not 11b and r/m is 100b. It is captured in `rec_sib_o` with `rec_has_sib_o` set, and its base field is bits 2:0.
- R7: With mod 00b and SIB base 101b, the displacement length becomes 4 bytes, whatever the lookup reported.
- R8: Size codes 0, 1, 2 and 3 mean 0, 1, 2 and 4 bytes. Displacement and immediate are assembled least-significant byte first, their lengths in bytes appear in `rec_disp_len_o` and `rec_imm_len_o`, and bytes not present read as zero.
- R9: `rec_len_o` equals the number of bytes accepted for the instruction, prefixes included.
- R10: While `rec_valid_o` is high, `in_ready_o` is low and no input byte is consumed. The record holds unchanged until `rec_ready_i` is seen, and `in_ready_o` returns high in the following cycle.
- R11: Reset puts the block in the prefix-scanning state with no record pending and discards any partly parsed instruction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| in_valid_i | input | 1 | Input byte valid |
| in_byte_i | input | 8 | Input byte |
| in_ready_o | output | 1 | Input byte accepted when high with valid |
| lk_byte_o | output | 8 | Opcode byte being looked up |
| lk_idx_o | output | 2 | Opcode bytes already taken |
| lk_more_i | input | 1 | Another opcode byte follows |
| lk_modrm_i | input | 1 | ModR/M byte present |
| lk_disp_sz_i | input | 2 | Displacement size code |
| lk_imm_sz_i | input | 2 | Immediate size code |
| rec_valid_o | output | 1 | Record valid |
| rec_ready_i | input | 1 | Record accepted |
| rec_grp1_o | output | 3 | Group 1 prefix mask |
| rec_grp2_o | output | 6 | Group 2 prefix mask |
| rec_grp3_o | output | 1 | Group 3 prefix seen |
| rec_grp4_o | output | 1 | Group 4 prefix seen |
| rec_err_o | output | 1 | Prefix rule violated |
| rec_opc_o | output | 24 | Opcode bytes, first in 7:0 |
| rec_opc_cnt_o | output | 2 | Opcode byte count |
| rec_has_modrm_o | output | 1 | ModR/M present |
| rec_modrm_o | output | 8 | ModR/M byte |
| rec_has_sib_o | output | 1 | SIB present |
| rec_sib_o | output | 8 | SIB byte |
| rec_disp_len_o | output | 3 | Displacement length in bytes |
| rec_disp_o | output | 32 | Displacement value |
| rec_imm_len_o | output | 3 | Immediate length in bytes |
| rec_imm_o | output | 32 | Immediate value |
| rec_len_o | output | 5 | Total instruction length |

## Verification
Bytes are driven at the falling edge and take effect at the next rising edge. The record is therefore due at the first falling edge after the final byte's rising edge, and that is where the bench compares every field and expects `in_ready_o` low. At every falling edge before that point, the bench expects the record absent and the input ready. It holds `rec_ready_i` low for a chosen number of cycles while offering a stray byte, then expects the record gone and the input ready exactly one cycle after `rec_ready_i` is raised. Expected fields come from a behavioural parse of the byte list in the bench, which uses the bench's own lookup table.

// File: rtl/ifs_pkg.sv
package ifs_pkg;
  localparam int unsigned G1_W = 3;
  localparam int unsigned G2_W = 6;
  localparam int unsigned SZ_W = 3;

  typedef enum logic [2:0] {
    ST_PFX, ST_OPC, ST_MODRM, ST_SIB, ST_DISP, ST_IMM, ST_OUT
  } seq_st_e;

  function automatic logic [SZ_W-1:0] sz_decode(input logic [1:0] code);
    return (code == 2'd3) ? SZ_W'(4) : {1'b0, code};
  endfunction

  // first state after the addressing bytes
  function automatic seq_st_e tail_st(input logic [SZ_W-1:0] d, input logic [SZ_W-1:0] i);
    if (d != '0) return ST_DISP;
    if (i != '0) return ST_IMM;
    return ST_OUT;
  endfunction
endpackage

// File: rtl/ifs_pfx_class.sv
module ifs_pfx_class
  import ifs_pkg::*;
(
  input  logic [7:0]      byte_i,
  output logic [G1_W-1:0] g1_o,
  output logic [G2_W-1:0] g2_o,
  output logic            g3_o,
  output logic            g4_o,
  output logic            hit_o
);
  always_comb begin
    g1_o = '0;
    g2_o = '0;
    g3_o = 1'b0;
    g4_o = 1'b0;
    unique case (byte_i)
      8'hF0: g1_o[0] = 1'b1;
      8'hF2: g1_o[1] = 1'b1;
      8'hF3: g1_o[2] = 1'b1;
      8'h26: g2_o[0] = 1'b1;
      8'h2E: g2_o[1] = 1'b1;
      8'h36: g2_o[2] = 1'b1;
      8'h3E: g2_o[3] = 1'b1;
      8'h64: g2_o[4] = 1'b1;
      8'h65: g2_o[5] = 1'b1;
      8'h66: g3_o = 1'b1;
      8'h67: g4_o = 1'b1;
      default: ;
    endcase
  end

  assign hit_o = (|g1_o) | (|g2_o) | g3_o | g4_o;

  always_comb begin
    a_r2_one_group: assert ($countones({g1_o, g2_o, g3_o, g4_o}) <= 1);
  end
endmodule

// File: rtl/ifs_le_acc.sv
module ifs_le_acc #(
  parameter int unsigned NB    = 4,
  localparam int unsigned IDX_W = $clog2(NB)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             wr_i,
  input  logic [IDX_W-1:0] idx_i,
  input  logic [7:0]       byte_i,
  output logic [8*NB-1:0]  val_o
);
  for (genvar g = 0; g < NB; g++) begin : g_lane
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                  val_o[8*g +: 8] <= '0;
      else if (clr_i)                               val_o[8*g +: 8] <= '0;
      else if (wr_i && (idx_i == IDX_W'(g)))        val_o[8*g +: 8] <= byte_i;
    end
  end

  a_r10_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> (val_o == '0));
  a_r8_one_lane: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_i && !clr_i |=> $stable(val_o));
endmodule

// File: rtl/ifld_seq.sv
module ifld_seq
  import ifs_pkg::*;
#(
  parameter int unsigned MAX_PFX = 4,
  parameter int unsigned MAX_OPC = 3,
  parameter int unsigned FLD_NB  = 4,
  parameter int unsigned LEN_W   = 5,
  localparam int unsigned OPC_W  = 8 * MAX_OPC,
  localparam int unsigned FLD_W  = 8 * FLD_NB,
  localparam int unsigned OCNT_W = $clog2(MAX_OPC + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              in_valid_i,
  input  logic [7:0]        in_byte_i,
  output logic              in_ready_o,
  output logic [7:0]        lk_byte_o,
  output logic [OCNT_W-1:0] lk_idx_o,
  input  logic              lk_more_i,
  input  logic              lk_modrm_i,
  input  logic [1:0]        lk_disp_sz_i,
  input  logic [1:0]        lk_imm_sz_i,
  output logic              rec_valid_o,
  input  logic              rec_ready_i,
  output logic [G1_W-1:0]   rec_grp1_o,
  output logic [G2_W-1:0]   rec_grp2_o,
  output logic              rec_grp3_o,
  output logic              rec_grp4_o,
  output logic              rec_err_o,
  output logic [OPC_W-1:0]  rec_opc_o,
  output logic [OCNT_W-1:0] rec_opc_cnt_o,
  output logic              rec_has_modrm_o,
  output logic [7:0]        rec_modrm_o,
  output logic              rec_has_sib_o,
  output logic [7:0]        rec_sib_o,
  output logic [SZ_W-1:0]   rec_disp_len_o,
  output logic [FLD_W-1:0]  rec_disp_o,
  output logic [SZ_W-1:0]   rec_imm_len_o,
  output logic [FLD_W-1:0]  rec_imm_o,
  output logic [LEN_W-1:0]  rec_len_o
);
  localparam int unsigned PCNT_W = $clog2(MAX_PFX + 2);
  localparam int unsigned OIDX_W = $clog2(MAX_OPC);
  localparam int unsigned FIDX_W = $clog2(FLD_NB);

  seq_st_e state_q;
  logic [G1_W-1:0]   g1_q;
  logic [G2_W-1:0]   g2_q;
  logic              g3_q, g4_q, err_q;
  logic [PCNT_W-1:0] pcnt_q;
  logic [OCNT_W-1:0] ocnt_q;
  logic              has_modrm_q, has_sib_q;
  logic [7:0]        modrm_q, sib_q;
  logic [SZ_W-1:0]   dlen_q, ilen_q;
  logic [FIDX_W-1:0] fidx_q;
  logic [LEN_W-1:0]  len_q;

  // prefix classification of the offered byte
  logic [G1_W-1:0] cls_g1;
  logic [G2_W-1:0] cls_g2;
  logic            cls_g3, cls_g4, cls_hit;

  ifs_pfx_class u_cls (
    .byte_i (in_byte_i),
    .g1_o   (cls_g1),
    .g2_o   (cls_g2),
    .g3_o   (cls_g3),
    .g4_o   (cls_g4),
    .hit_o  (cls_hit)
  );

  logic fire, rec_fire, in_pfx, in_opc, take_opc;
  logic pfx_dup, pfx_full, opc_last, need_sib, disp_force;
  logic fld_last_d, fld_last_i;
  logic [SZ_W-1:0] lk_dlen, lk_ilen, sib_dlen;
  seq_st_e opc_nxt;

  assign in_ready_o = (state_q != ST_OUT);
  assign rec_valid_o = (state_q == ST_OUT);
  assign fire     = in_valid_i && in_ready_o;
  assign rec_fire = rec_valid_o && rec_ready_i;
  assign in_pfx   = (state_q == ST_PFX);
  assign in_opc   = (in_pfx && !cls_hit) || (state_q == ST_OPC);
  assign take_opc = fire && in_opc;

  assign lk_byte_o = in_byte_i;
  assign lk_idx_o  = (state_q == ST_OPC) ? ocnt_q : '0;

  assign pfx_dup  = ((|cls_g1) && (|g1_q)) || ((|cls_g2) && (|g2_q)) ||
                    (cls_g3 && g3_q) || (cls_g4 && g4_q);
  assign pfx_full = (pcnt_q >= PCNT_W'(MAX_PFX));

  assign lk_dlen  = sz_decode(lk_disp_sz_i);
  assign lk_ilen  = sz_decode(lk_imm_sz_i);
  assign opc_last = !lk_more_i || (lk_idx_o == OCNT_W'(MAX_OPC - 1));

  always_comb begin
    if (!opc_last)       opc_nxt = ST_OPC;
    else if (lk_modrm_i) opc_nxt = ST_MODRM;
    else                 opc_nxt = tail_st(lk_dlen, lk_ilen);
  end

  assign need_sib   = (in_byte_i[7:6] != 2'b11) && (in_byte_i[2:0] == 3'b100);
  assign disp_force = (modrm_q[7:6] == 2'b00) && (in_byte_i[2:0] == 3'b101);
  assign sib_dlen   = disp_force ? SZ_W'(4) : dlen_q;
  assign fld_last_d = ({{(SZ_W-FIDX_W){1'b0}}, fidx_q} == dlen_q - SZ_W'(1));
  assign fld_last_i = ({{(SZ_W-FIDX_W){1'b0}}, fidx_q} == ilen_q - SZ_W'(1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q     <= ST_PFX;
      g1_q        <= '0;
      g2_q        <= '0;
      g3_q        <= 1'b0;
      g4_q        <= 1'b0;
      err_q       <= 1'b0;
      pcnt_q      <= '0;
      ocnt_q      <= '0;
      has_modrm_q <= 1'b0;
      has_sib_q   <= 1'b0;
      modrm_q     <= '0;
      sib_q       <= '0;
      dlen_q      <= '0;
      ilen_q      <= '0;
      fidx_q      <= '0;
      len_q       <= '0;
    end else begin
      if (fire && !(&len_q)) len_q <= len_q + LEN_W'(1);
      if (take_opc) begin
        ocnt_q      <= ocnt_q + OCNT_W'(1);
        has_modrm_q <= lk_modrm_i;
        dlen_q      <= lk_dlen;
        ilen_q      <= lk_ilen;
        state_q     <= opc_nxt;
      end
      unique case (state_q)
        ST_PFX: begin
          if (fire && cls_hit) begin
            g1_q <= g1_q | cls_g1;
            g2_q <= g2_q | cls_g2;
            g3_q <= g3_q | cls_g3;
            g4_q <= g4_q | cls_g4;
            if (pfx_dup || pfx_full) err_q <= 1'b1;
            if (!(&pcnt_q)) pcnt_q <= pcnt_q + PCNT_W'(1);
          end
        end
        ST_OPC: ;
        ST_MODRM: begin
          if (fire) begin
            modrm_q <= in_byte_i;
            state_q <= need_sib ? ST_SIB : tail_st(dlen_q, ilen_q);
          end
        end
        ST_SIB: begin
          if (fire) begin
            sib_q     <= in_byte_i;
            has_sib_q <= 1'b1;
            dlen_q    <= sib_dlen;
            state_q   <= tail_st(sib_dlen, ilen_q);
          end
        end
        ST_DISP: begin
          if (fire) begin
            if (fld_last_d) begin
              fidx_q  <= '0;
              state_q <= (ilen_q != '0) ? ST_IMM : ST_OUT;
            end else begin
              fidx_q <= fidx_q + FIDX_W'(1);
            end
          end
        end
        ST_IMM: begin
          if (fire) begin
            if (fld_last_i) begin
              fidx_q  <= '0;
              state_q <= ST_OUT;
            end else begin
              fidx_q <= fidx_q + FIDX_W'(1);
            end
          end
        end
        ST_OUT: begin
          if (rec_ready_i) begin
            state_q     <= ST_PFX;
            g1_q        <= '0;
            g2_q        <= '0;
            g3_q        <= 1'b0;
            g4_q        <= 1'b0;
            err_q       <= 1'b0;
            pcnt_q      <= '0;
            ocnt_q      <= '0;
            has_modrm_q <= 1'b0;
            has_sib_q   <= 1'b0;
            modrm_q     <= '0;
            sib_q       <= '0;
            dlen_q      <= '0;
            ilen_q      <= '0;
            fidx_q      <= '0;
            len_q       <= '0;
          end
        end
        default: state_q <= ST_PFX;
      endcase
    end
  end

  ifs_le_acc #(.NB(MAX_OPC)) u_opc (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (rec_fire),
    .wr_i   (take_opc),
    .idx_i  (lk_idx_o[OIDX_W-1:0]),
    .byte_i (in_byte_i),
    .val_o  (rec_opc_o)
  );

  ifs_le_acc #(.NB(FLD_NB)) u_disp (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (rec_fire),
    .wr_i   (fire && (state_q == ST_DISP)),
    .idx_i  (fidx_q),
    .byte_i (in_byte_i),
    .val_o  (rec_disp_o)
  );

  ifs_le_acc #(.NB(FLD_NB)) u_imm (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (rec_fire),
    .wr_i   (fire && (state_q == ST_IMM)),
    .idx_i  (fidx_q),
    .byte_i (in_byte_i),
    .val_o  (rec_imm_o)
  );

  assign rec_grp1_o      = g1_q;
  assign rec_grp2_o      = g2_q;
  assign rec_grp3_o      = g3_q;
  assign rec_grp4_o      = g4_q;
  assign rec_err_o       = err_q;
  assign rec_opc_cnt_o   = ocnt_q;
  assign rec_has_modrm_o = has_modrm_q;
  assign rec_modrm_o     = modrm_q;
  assign rec_has_sib_o   = has_sib_q;
  assign rec_sib_o       = sib_q;
  assign rec_disp_len_o  = dlen_q;
  assign rec_imm_len_o   = ilen_q;
  assign rec_len_o       = len_q;

  a_r10_stall: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rec_valid_o |-> !in_ready_o);
  a_r10_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rec_valid_o && !rec_ready_i |=> rec_valid_o && $stable(rec_len_o) &&
      $stable(rec_opc_o) && $stable(rec_disp_o) && $stable(rec_imm_o));
  a_r10_release: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rec_valid_o && rec_ready_i |=> !rec_valid_o && in_ready_o);
  a_r2_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rec_valid_o && !rec_err_o |-> $onehot0(rec_grp1_o) && $onehot0(rec_grp2_o));
  a_r4_opc_cnt: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rec_valid_o |-> (rec_opc_cnt_o != '0) && (rec_opc_cnt_o <= OCNT_W'(MAX_OPC)));
  a_r6_sib_cond: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rec_valid_o && rec_has_sib_o |-> rec_has_modrm_o &&
      (rec_modrm_o[7:6] != 2'b11) && (rec_modrm_o[2:0] == 3'b100));
  a_r7_disp_four: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rec_valid_o && rec_has_sib_o && (rec_modrm_o[7:6] == 2'b00) &&
      (rec_sib_o[2:0] == 3'b101) |-> (rec_disp_len_o == SZ_W'(4)));
  a_r9_len: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rec_valid_o && !rec_err_o |-> int'(rec_len_o) ==
      $countones({rec_grp1_o, rec_grp2_o, rec_grp3_o, rec_grp4_o}) +
      int'(rec_opc_cnt_o) + int'(rec_has_modrm_o) + int'(rec_has_sib_o) +
      int'(rec_disp_len_o) + int'(rec_imm_len_o));
endmodule

// File: tb/ifld_seq_test.sv
module ifld_seq_test;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        in_valid = 1'b0;
  logic [7:0]  in_byte = 8'h00;
  logic        in_ready;
  logic [7:0]  lk_byte;
  logic [1:0]  lk_idx;
  logic        lk_more, lk_modrm;
  logic [1:0]  lk_dsz, lk_isz;
  logic        rec_valid;
  logic        rec_ready = 1'b0;
  logic [2:0]  r_g1;
  logic [5:0]  r_g2;
  logic        r_g3, r_g4, r_err;
  logic [23:0] r_opc;
  logic [1:0]  r_ocnt;
  logic        r_hm, r_hs;
  logic [7:0]  r_modrm, r_sib;
  logic [2:0]  r_dlen, r_ilen;
  logic [31:0] r_disp, r_imm;
  logic [4:0]  r_len;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  ifld_seq uut (
    .clk_i(clk), .rst_ni(rst_ni), .in_valid_i(in_valid), .in_byte_i(in_byte),
    .in_ready_o(in_ready), .lk_byte_o(lk_byte), .lk_idx_o(lk_idx),
    .lk_more_i(lk_more), .lk_modrm_i(lk_modrm), .lk_disp_sz_i(lk_dsz),
    .lk_imm_sz_i(lk_isz), .rec_valid_o(rec_valid), .rec_ready_i(rec_ready),
    .rec_grp1_o(r_g1), .rec_grp2_o(r_g2), .rec_grp3_o(r_g3), .rec_grp4_o(r_g4),
    .rec_err_o(r_err), .rec_opc_o(r_opc), .rec_opc_cnt_o(r_ocnt),
    .rec_has_modrm_o(r_hm), .rec_modrm_o(r_modrm), .rec_has_sib_o(r_hs),
    .rec_sib_o(r_sib), .rec_disp_len_o(r_dlen), .rec_disp_o(r_disp),
    .rec_imm_len_o(r_ilen), .rec_imm_o(r_imm), .rec_len_o(r_len)
  );

  // bench lookup table: {more, modrm, disp code, imm code}
  function automatic logic [5:0] lk_fn(input logic [1:0] idx, input logic [7:0] b);
    if (idx == 2'd0) begin
      case (b)
        8'h0F: return 6'b10_00_00;
        8'h8B: return 6'b01_00_00;
        8'hB8: return 6'b00_00_10;
        8'h80: return 6'b01_01_01;
        8'hA1: return 6'b00_11_00;
        8'hC7: return 6'b01_00_11;
        default: return 6'b00_00_00;
      endcase
    end else if (idx == 2'd1) begin
      case (b)
        8'h38: return 6'b10_00_00;
        8'h80: return 6'b00_00_11;
        default: return 6'b00_00_00;
      endcase
    end else begin
      case (b)
        8'h00: return 6'b01_00_00;
        8'hFF: return 6'b10_00_00;
        default: return 6'b00_00_00;
      endcase
    end
  endfunction

  always_comb {lk_more, lk_modrm, lk_dsz, lk_isz} = lk_fn(lk_idx, lk_byte);

  // expected record
  logic [7:0]  q[$];
  logic [2:0]  e_g1;
  logic [5:0]  e_g2;
  logic        e_g3, e_g4, e_err, e_hm, e_hs;
  logic [23:0] e_opc;
  logic [1:0]  e_ocnt;
  logic [7:0]  e_modrm, e_sib;
  logic [2:0]  e_dlen, e_ilen;
  logic [31:0] e_disp, e_imm;
  logic [4:0]  e_len;

  task automatic chk(input string req, input string what, input logic [31:0] act,
                     input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  function automatic int bytes_of(input logic [1:0] c);
    return (c == 2'd3) ? 4 : int'(c);
  endfunction

  task automatic ref_parse();
    int i = 0;
    int np = 0;
    logic [5:0] lk;
    e_g1 = '0; e_g2 = '0; e_g3 = 0; e_g4 = 0; e_err = 0; e_hm = 0; e_hs = 0;
    e_opc = '0; e_ocnt = '0; e_modrm = '0; e_sib = '0; e_disp = '0; e_imm = '0;
    e_dlen = '0; e_ilen = '0;
    forever begin
      logic [7:0] b = q[i];
      int grp = 0;
      int bit_n = 0;
      case (b)
        8'hF0: begin grp = 1; bit_n = 0; end
        8'hF2: begin grp = 1; bit_n = 1; end
        8'hF3: begin grp = 1; bit_n = 2; end
        8'h26: begin grp = 2; bit_n = 0; end
        8'h2E: begin grp = 2; bit_n = 1; end
        8'h36: begin grp = 2; bit_n = 2; end
        8'h3E: begin grp = 2; bit_n = 3; end
        8'h64: begin grp = 2; bit_n = 4; end
        8'h65: begin grp = 2; bit_n = 5; end
        8'h66: grp = 3;
        8'h67: grp = 4;
        default: grp = 0;
      endcase
      if (grp == 0) break;
      if (np >= 4) e_err = 1;
      if (grp == 1) begin if (e_g1 != 0) e_err = 1; e_g1[bit_n] = 1; end
      if (grp == 2) begin if (e_g2 != 0) e_err = 1; e_g2[bit_n] = 1; end
      if (grp == 3) begin if (e_g3) e_err = 1; e_g3 = 1; end
      if (grp == 4) begin if (e_g4) e_err = 1; e_g4 = 1; end
      np++; i++;
    end
    forever begin
      lk = lk_fn(e_ocnt, q[i]);
      e_opc[8*e_ocnt +: 8] = q[i];
      e_ocnt++; i++;
      e_hm = lk[4];
      e_dlen = 3'(bytes_of(lk[3:2]));
      e_ilen = 3'(bytes_of(lk[1:0]));
      if (!lk[5] || e_ocnt == 2'd3) break;
    end
    if (e_hm) begin
      e_modrm = q[i]; i++;
      if (e_modrm[7:6] != 2'b11 && e_modrm[2:0] == 3'b100) begin
        e_hs = 1; e_sib = q[i]; i++;
        if (e_modrm[7:6] == 2'b00 && e_sib[2:0] == 3'b101) e_dlen = 3'd4;
      end
    end
    for (int k = 0; k < int'(e_dlen); k++) begin e_disp[8*k +: 8] = q[i]; i++; end
    for (int k = 0; k < int'(e_ilen); k++) begin e_imm[8*k +: 8] = q[i]; i++; end
    e_len = 5'(i);
  endtask

  task automatic cmp_rec(input string tag);
    chk("R2", {tag, " grp1"}, 32'(r_g1), 32'(e_g1));
    chk("R2", {tag, " grp2"}, 32'(r_g2), 32'(e_g2));
    chk("R2", {tag, " grp34"}, {30'd0, r_g3, r_g4}, {30'd0, e_g3, e_g4});
    chk("R3", {tag, " err"}, 32'(r_err), 32'(e_err));
    chk("R4", {tag, " opcode"}, 32'(r_opc), 32'(e_opc));
    chk("R4", {tag, " opcode count"}, 32'(r_ocnt), 32'(e_ocnt));
    chk("R5", {tag, " modrm"}, {23'd0, r_hm, r_modrm}, {23'd0, e_hm, e_modrm});
    chk("R6", {tag, " sib"}, {23'd0, r_hs, r_sib}, {23'd0, e_hs, e_sib});
    chk("R7", {tag, " disp len"}, 32'(r_dlen), 32'(e_dlen));
    chk("R8", {tag, " disp"}, r_disp, e_disp);
    chk("R8", {tag, " imm len"}, 32'(r_ilen), 32'(e_ilen));
    chk("R8", {tag, " imm"}, r_imm, e_imm);
    chk("R9", {tag, " length"}, 32'(r_len), 32'(e_len));
  endtask

  task automatic run_insn(input string tag, input int gap, input int hold);
    ref_parse();
    for (int k = 0; k < q.size(); k++) begin
      if (gap > 0 && k > 0) begin
        @(negedge clk);
        in_valid = 0; in_byte = 8'hF0;
        chk("R1", {tag, " early record"}, 32'(rec_valid), 0);
      end
      @(negedge clk);
      chk("R1", {tag, " early record"}, 32'(rec_valid), 0);
      chk("R10", {tag, " ready"}, 32'(in_ready), 1);
      in_valid = 1; in_byte = q[k];
    end
    @(negedge clk);
    in_valid = 1; in_byte = 8'h66;
    chk("R1", {tag, " record due"}, 32'(rec_valid), 1);
    chk("R10", {tag, " stall"}, 32'(in_ready), 0);
    cmp_rec(tag);
    for (int h = 0; h < hold; h++) begin
      @(negedge clk);
      chk("R10", {tag, " held valid"}, 32'(rec_valid), 1);
      chk("R10", {tag, " stall held"}, 32'(in_ready), 0);
      cmp_rec(tag);
    end
    rec_ready = 1;
    @(negedge clk);
    chk("R10", {tag, " released"}, {31'd0, rec_valid}, 0);
    chk("R10", {tag, " ready again"}, 32'(in_ready), 1);
    rec_ready = 0; in_valid = 0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_ni = 1;
    @(negedge clk);
    chk("R11", "reset valid", 32'(rec_valid), 0);
    chk("R11", "reset ready", 32'(in_ready), 1);

    q = '{8'h90};                                   run_insn("one byte", 0, 0);
    q = '{8'h66, 8'hB8, 8'h34, 8'h12};             run_insn("imm2", 0, 2);
    q = '{8'h8B, 8'hC8};                            run_insn("modrm reg", 1, 0);
    q = '{8'h8B, 8'h04, 8'h24};                     run_insn("sib", 0, 0);
    q = '{8'h8B, 8'h04, 8'h25, 8'h78, 8'h56, 8'h34, 8'h12};
    run_insn("R7 forced disp", 0, 1);
    q = '{8'h8B, 8'h44, 8'h25};                     run_insn("sib mod01", 0, 0);
    q = '{8'h0F, 8'h38, 8'h00, 8'hC1};              run_insn("three opc", 1, 0);
    q = '{8'h0F, 8'h38, 8'hFF};                     run_insn("R4 opc cap", 0, 0);
    q = '{8'h0F, 8'h80, 8'hEF, 8'hBE, 8'hAD, 8'hDE}; run_insn("two opc imm4", 0, 0);
    q = '{8'hA1, 8'h11, 8'h22, 8'h33, 8'h44};       run_insn("disp4", 1, 0);
    q = '{8'h3E, 8'hC7, 8'h05, 8'h01, 8'h02, 8'h03, 8'h04};
    run_insn("modrm imm4", 0, 0);
    q = '{8'h80, 8'h40, 8'h08, 8'h7F};              run_insn("disp1 imm1", 0, 3);
    q = '{8'hF0, 8'hF3, 8'h90};                     run_insn("R3 dup group", 0, 0);
    q = '{8'hF2, 8'h2E, 8'h66, 8'h67, 8'h0F, 8'h38, 8'h00, 8'hC0};
    run_insn("R2 four groups", 0, 0);
    q = '{8'h66, 8'h67, 8'h64, 8'hF0, 8'h66, 8'h90};
    run_insn("R3 fifth prefix", 0, 0);

    // R11: reset in the middle of an instruction
    @(negedge clk); in_valid = 1; in_byte = 8'h66;
    @(negedge clk); in_byte = 8'h8B;
    @(negedge clk); in_valid = 0; rst_ni = 0;
    @(negedge clk);
    chk("R11", "mid reset valid", 32'(rec_valid), 0);
    chk("R11", "mid reset ready", 32'(in_ready), 1);
    rst_ni = 1;
    q = '{8'hB8, 8'hCD, 8'hAB};                     run_insn("R11 after reset", 0, 0);

    repeat (2) @(negedge clk);
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end
endmodule